// File: doc/BRIEF.md
# ECC Error Capture Registers

This block is the reporting side of a DRAM controller's ECC path. The checker that sits on the read path gives it one pulse per failing transfer, marked as either a correctable (single-bit) or uncorrectable (multi-bit) error. Each pulse comes with the data, the check bits and the address of that transfer. The block keeps sticky detect flags and freezes a snapshot of the first reported failure. It counts correctable errors against a programmable threshold, so that only every Nth one is reported. It also drives an interrupt line that can be enabled separately for each error class.

The same register window holds the error-injection settings for the write path: two 32-bit data masks and a check-bit mask, guarded by an enable bit. The write path XORs the masks into the data and check bits it stores. The masks leave the block as zero whenever injection is off, so the write path needs no gating of its own.

Software reaches every register through a plain 32-bit port that is indexed by word. Reads are combinational. Writes take effect at the clock edge.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every register reads zero, except the error-count register, which reads 0x00010000 (threshold 1, count 0). `irq` is low and all injection outputs are zero.
- R2: An uncorrectable pulse that is not masked sets detect bit 1 at the next clock edge. The bit stays set until software clears it.
- R3: Each unmasked correctable pulse increments the count held in bits 7:0 of the error-count register. The threshold is in bits 23:16, and a software write does not load the count. With a nonzero threshold, a pulse that brings the count to the threshold or past it sets detect bit 0 and returns the count to zero. With threshold 0, the count wraps modulo 256 and nothing is ever reported.
- R4: The disable register masks error classes: bit 0 masks correctable errors and bit 1 masks uncorrectable errors. A masked pulse changes neither the detect bits, nor the count, nor the capture registers. Writing 0 unmasks both classes.
- R5: Writing the detect register clears every bit that is 1 in the written value. When an error sets a bit in the same cycle as a clear of that bit, the set wins.
- R6: The capture registers load only on a reported error that arrives while both detect bits are zero. While any detect bit is set, they hold their value.
- R7: The captured check field depends on `bus_narrow`. When it is 0, only bits 7:0 of `ev_chk` are kept. When it is 1, all 16 bits are kept. Unused bits read as zero.
- R8: `irq` is registered and equals the OR of detect bit 0 AND enable bit 0 with detect bit 1 AND enable bit 1. It changes at the same clock edge as the detect and enable bits.
- R9: The injection control register uses bits 7:0 as the check-bit mask and bit 8 as the enable, and reads back only bits 8:0. While bit 8 is set, `inj_mask_hi`, `inj_mask_lo` and `inj_mask_chk` carry the programmed masks. While it is clear, all three are zero.
- R10: The register word indices are fixed as follows.
  - 0: detect
  - 1: disable
  - 2: interrupt enable
  - 3: error count
  - 4: captured data, high word
  - 5: captured data, low word
  - 6: captured check bits
  - 7: captured address, low part
  - 8: captured address, upper part
  - 9: injection mask, high word
  - 10: injection mask, low word
  - 11: injection control

  Writes to indices 4 to 8 are ignored. Reads of indices 12 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_sbe | input | 1 | Correctable-error pulse from the checker |
| ev_mbe | input | 1 | Uncorrectable-error pulse from the checker |
| ev_data_hi | input | 32 | Upper data word of the failing transfer |
| ev_data_lo | input | 32 | Lower data word of the failing transfer |
| ev_chk | input | 16 | Check bits of the failing transfer |
| ev_addr_lo | input | 32 | Low part of the failing address |
| ev_addr_ext | input | 8 | Upper part of the failing address |
| bus_narrow | input | 1 | 1 = 32-bit data bus (16 check bits kept) |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| inj_mask_hi | output | 32 | Data-mask upper word for the write path |
| inj_mask_lo | output | 32 | Data-mask lower word for the write path |
| inj_mask_chk | output | 8 | Check-bit mask for the write path |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench goes after four corner cases.

- **Set and clear in the same cycle.** The bench clears a detect bit in the same cycle that a new error sets it. A design that let the clear win would lose that error and leave `irq` low.
- **Second error while a flag is pending.** A design that captured on every error would overwrite the first failure's snapshot.
- **Threshold behaviour.** The bench uses a threshold of 3, then threshold 0 (count wraps, no report), then a threshold set below the running count. A design that compared for equality would never report in the last case, and one that forgot to return the count to zero would report on every later pulse.
- **Masked errors and gated outputs.** Masked pulses, narrow and wide check capture, and injection with the enable bit clear are each checked against a cycle-by-cycle model.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

   // register word indices (software-visible map)
   localparam int REG_IDX_W = 4;
   typedef enum logic [REG_IDX_W-1:0] {
      RI_DETECT   = 4'd0,
      RI_DISABLE  = 4'd1,
      RI_INTEN    = 4'd2,
      RI_SBEMGT   = 4'd3,
      RI_CAP_HI   = 4'd4,
      RI_CAP_LO   = 4'd5,
      RI_CAP_CHK  = 4'd6,
      RI_CAP_ALO  = 4'd7,
      RI_CAP_AEXT = 4'd8,
      RI_INJ_HI   = 4'd9,
      RI_INJ_LO   = 4'd10,
      RI_INJ_CTL  = 4'd11
   } reg_idx_e;

   // error classes: bit position in detect / disable / enable registers
   localparam int ERR_SBE = 0;
   localparam int ERR_MBE = 1;
   localparam int NUM_ERR = 2;

   // error-count register layout
   localparam int THR_LSB = 16;
   localparam int CNT_MAX_W = 8;

   // register word width
   localparam int WORD_W = 32;

endpackage

// File: rtl/ecc_sbe_thresh.sv
module ecc_sbe_thresh #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic [CNT_W-1:0] thr,
   output logic             report,
   output logic [CNT_W-1:0] cnt
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   inc;

   assign inc    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign report = hit && (thr != '0) && (inc >= {1'b0, thr});
   assign cnt    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hit) begin
         cnt_q <= report ? '0 : inc[CNT_W-1:0];
      end
   end

   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      report |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/ecc_err_latch.sv
module ecc_err_latch
   import ecc_err_pkg::*;
#(
   parameter int DW       = 32,
   parameter int CHK_W    = 16,
   parameter int WIDE_CHK = 8,
   parameter int AEXT_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] set,
   input  logic [NUM_ERR-1:0] clr,
   input  logic [NUM_ERR-1:0] ien_d,
   input  logic               narrow,
   input  logic [DW-1:0]      data_hi,
   input  logic [DW-1:0]      data_lo,
   input  logic [CHK_W-1:0]   chk,
   input  logic [DW-1:0]      addr_lo,
   input  logic [AEXT_W-1:0]  addr_ext,
   output logic [NUM_ERR-1:0] det,
   output logic               irq,
   output logic [DW-1:0]      cap_hi,
   output logic [DW-1:0]      cap_lo,
   output logic [CHK_W-1:0]   cap_chk,
   output logic [DW-1:0]      cap_alo,
   output logic [AEXT_W-1:0]  cap_aext
);

   logic [NUM_ERR-1:0] det_q, det_d;
   logic               irq_q;
   logic               load;
   logic [CHK_W-1:0]   chk_m;
   logic [DW-1:0]      cap_hi_q, cap_lo_q, cap_alo_q;
   logic [CHK_W-1:0]   cap_chk_q;
   logic [AEXT_W-1:0]  cap_aext_q;

   // per-class sticky flag: new set dominates software clear
   for (genvar e = 0; e < NUM_ERR; e++) begin : g_det
      assign det_d[e] = (det_q[e] & ~clr[e]) | set[e];
   end

   // check-bit field: low bits always kept, upper bits only in narrow mode
   for (genvar b = 0; b < CHK_W; b++) begin : g_chk
      if (b < WIDE_CHK) begin : g_keep
         assign chk_m[b] = chk[b];
      end else begin : g_narrow
         assign chk_m[b] = chk[b] & narrow;
      end
   end

   assign load = (set != '0) && (det_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         det_q      <= '0;
         irq_q      <= 1'b0;
         cap_hi_q   <= '0;
         cap_lo_q   <= '0;
         cap_chk_q  <= '0;
         cap_alo_q  <= '0;
         cap_aext_q <= '0;
      end else begin
         det_q <= det_d;
         irq_q <= |(det_d & ien_d);
         if (load) begin
            cap_hi_q   <= data_hi;
            cap_lo_q   <= data_lo;
            cap_chk_q  <= chk_m;
            cap_alo_q  <= addr_lo;
            cap_aext_q <= addr_ext;
         end
      end
   end

   assign det      = det_q;
   assign irq      = irq_q;
   assign cap_hi   = cap_hi_q;
   assign cap_lo   = cap_lo_q;
   assign cap_chk  = cap_chk_q;
   assign cap_alo  = cap_alo_q;
   assign cap_aext = cap_aext_q;

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (set != '0) |=> ((det_q & $past(set)) == $past(set))); // R2

   AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr != '0) && (set == '0)) |=> ((det_q & $past(clr)) == '0)); // R5

   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (det_q != '0) |=> ($stable(cap_hi_q) && $stable(cap_chk_q) && $stable(cap_alo_q))); // R6

endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
   import ecc_err_pkg::*;
#(
   parameter int DW        = 32,
   parameter int INJ_CHK_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [REG_IDX_W-1:0] idx,
   input  logic [DW-1:0]        wdata,
   output logic [DW-1:0]        hi_rd,
   output logic [DW-1:0]        lo_rd,
   output logic [INJ_CHK_W:0]   ctl_rd,
   output logic [DW-1:0]        mask_hi,
   output logic [DW-1:0]        mask_lo,
   output logic [INJ_CHK_W-1:0] mask_chk
);

   localparam int EN_BIT = INJ_CHK_W;

   logic [DW-1:0]      hi_q, lo_q;
   logic [INJ_CHK_W:0] ctl_q;
   logic               active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         ctl_q <= '0;
      end else if (wr) begin
         if (idx == RI_INJ_HI)  hi_q  <= wdata;
         if (idx == RI_INJ_LO)  lo_q  <= wdata;
         if (idx == RI_INJ_CTL) ctl_q <= wdata[INJ_CHK_W:0];
      end
   end

   assign active   = ctl_q[EN_BIT];
   assign mask_hi  = active ? hi_q : '0;
   assign mask_lo  = active ? lo_q : '0;
   assign mask_chk = active ? ctl_q[INJ_CHK_W-1:0] : '0;

   assign hi_rd  = hi_q;
   assign lo_rd  = lo_q;
   assign ctl_rd = ctl_q;

   AST_INJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr) |=> ($stable(hi_q) && $stable(ctl_q))); // R9

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
   import ecc_err_pkg::*;
#(
   parameter int CHK_W     = 16,
   parameter int WIDE_CHK  = 8,
   parameter int AEXT_W    = 8,
   parameter int CNT_W     = 8,
   parameter int INJ_CHK_W = 8,
   parameter int THR_RST   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ev_sbe,
   input  logic                 ev_mbe,
   input  logic [WORD_W-1:0]    ev_data_hi,
   input  logic [WORD_W-1:0]    ev_data_lo,
   input  logic [CHK_W-1:0]     ev_chk,
   input  logic [WORD_W-1:0]    ev_addr_lo,
   input  logic [AEXT_W-1:0]    ev_addr_ext,
   input  logic                 bus_narrow,
   input  logic                 reg_en,
   input  logic                 reg_we,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [WORD_W-1:0]    reg_wdata,
   output logic [WORD_W-1:0]    reg_rdata,
   output logic [WORD_W-1:0]    inj_mask_hi,
   output logic [WORD_W-1:0]    inj_mask_lo,
   output logic [INJ_CHK_W-1:0] inj_mask_chk,
   output logic                 irq
);

   localparam logic [CNT_W-1:0] THR_INIT = CNT_W'(THR_RST);

   initial begin
      assert (CHK_W >= WIDE_CHK && CHK_W <= WORD_W) else $error("CHK_W out of range");
      assert (AEXT_W >= 1 && AEXT_W <= WORD_W) else $error("AEXT_W out of range");
      assert (CNT_W >= 1 && CNT_W <= CNT_MAX_W) else $error("CNT_W out of range");
      assert (INJ_CHK_W >= 1 && INJ_CHK_W < WORD_W) else $error("INJ_CHK_W out of range");
   end

   logic               wr;
   logic [NUM_ERR-1:0] dis_q, ien_q, ien_d;
   logic [CNT_W-1:0]   thr_q;
   logic [CNT_W-1:0]   sbe_cnt;
   logic               sbe_hit, sbe_rep, mbe_set;
   logic [NUM_ERR-1:0] set_v, clr_v, det;
   logic [WORD_W-1:0]  cap_hi, cap_lo, cap_alo;
   logic [CHK_W-1:0]   cap_chk;
   logic [AEXT_W-1:0]  cap_aext;
   logic [WORD_W-1:0]  inj_hi_rd, inj_lo_rd;
   logic [INJ_CHK_W:0] inj_ctl_rd;

   assign wr = reg_en & reg_we;

   // configuration registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dis_q <= '0;
         ien_q <= '0;
         thr_q <= THR_INIT;
      end else if (wr) begin
         if (reg_addr == RI_DISABLE) dis_q <= reg_wdata[NUM_ERR-1:0];
         if (reg_addr == RI_INTEN)   ien_q <= reg_wdata[NUM_ERR-1:0];
         if (reg_addr == RI_SBEMGT)  thr_q <= reg_wdata[THR_LSB +: CNT_W];
      end
   end

   assign ien_d = (wr && reg_addr == RI_INTEN) ? reg_wdata[NUM_ERR-1:0] : ien_q;

   assign sbe_hit = ev_sbe & ~dis_q[ERR_SBE];
   assign mbe_set = ev_mbe & ~dis_q[ERR_MBE];

   always_comb begin
      set_v          = '0;
      set_v[ERR_SBE] = sbe_rep;
      set_v[ERR_MBE] = mbe_set;
      clr_v = (wr && reg_addr == RI_DETECT) ? reg_wdata[NUM_ERR-1:0] : '0;
   end

   ecc_sbe_thresh #(.CNT_W(CNT_W)) thresh_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (sbe_hit),
      .thr    (thr_q),
      .report (sbe_rep),
      .cnt    (sbe_cnt)
   );

   ecc_err_latch #(
      .DW       (WORD_W),
      .CHK_W    (CHK_W),
      .WIDE_CHK (WIDE_CHK),
      .AEXT_W   (AEXT_W)
   ) latch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (set_v),
      .clr      (clr_v),
      .ien_d    (ien_d),
      .narrow   (bus_narrow),
      .data_hi  (ev_data_hi),
      .data_lo  (ev_data_lo),
      .chk      (ev_chk),
      .addr_lo  (ev_addr_lo),
      .addr_ext (ev_addr_ext),
      .det      (det),
      .irq      (irq),
      .cap_hi   (cap_hi),
      .cap_lo   (cap_lo),
      .cap_chk  (cap_chk),
      .cap_alo  (cap_alo),
      .cap_aext (cap_aext)
   );

   ecc_inj_ctrl #(.DW(WORD_W), .INJ_CHK_W(INJ_CHK_W)) inj_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr),
      .idx      (reg_addr),
      .wdata    (reg_wdata),
      .hi_rd    (inj_hi_rd),
      .lo_rd    (inj_lo_rd),
      .ctl_rd   (inj_ctl_rd),
      .mask_hi  (inj_mask_hi),
      .mask_lo  (inj_mask_lo),
      .mask_chk (inj_mask_chk)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RI_DETECT:   reg_rdata[NUM_ERR-1:0] = det;
         RI_DISABLE:  reg_rdata[NUM_ERR-1:0] = dis_q;
         RI_INTEN:    reg_rdata[NUM_ERR-1:0] = ien_q;
         RI_SBEMGT: begin
            reg_rdata[THR_LSB +: CNT_W] = thr_q;
            reg_rdata[CNT_W-1:0]        = sbe_cnt;
         end
         RI_CAP_HI:   reg_rdata = cap_hi;
         RI_CAP_LO:   reg_rdata = cap_lo;
         RI_CAP_CHK:  reg_rdata[CHK_W-1:0] = cap_chk;
         RI_CAP_ALO:  reg_rdata = cap_alo;
         RI_CAP_AEXT: reg_rdata[AEXT_W-1:0] = cap_aext;
         RI_INJ_HI:   reg_rdata = inj_hi_rd;
         RI_INJ_LO:   reg_rdata = inj_lo_rd;
         RI_INJ_CTL:  reg_rdata[INJ_CHK_W:0] = inj_ctl_rd;
         default:     reg_rdata = '0;
      endcase
   end

   AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(det & ien_q)); // R8

   AST_MASKED_MBE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_mbe && dis_q[ERR_MBE] && !det[ERR_MBE]) |=> !det[ERR_MBE]); // R4

endmodule

// File: tb/ecc_err_capture_tb_top.sv
`timescale 1ns/1ps
module ecc_err_capture_tb_top;
   import ecc_err_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_sbe = 1'b0, ev_mbe = 1'b0;
   logic [31:0] ev_data_hi = '0, ev_data_lo = '0, ev_addr_lo = '0;
   logic [15:0] ev_chk = '0;
   logic [7:0]  ev_addr_ext = '0;
   logic        bus_narrow = 1'b0;
   logic        reg_en = 1'b0, reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, inj_mask_hi, inj_mask_lo;
   logic [7:0]  inj_mask_chk;
   logic        irq;

   always #4 clk = ~clk;

   ecc_err_capture dut_i (
      .clk(clk), .rst_n(rst_n), .ev_sbe(ev_sbe), .ev_mbe(ev_mbe),
      .ev_data_hi(ev_data_hi), .ev_data_lo(ev_data_lo), .ev_chk(ev_chk),
      .ev_addr_lo(ev_addr_lo), .ev_addr_ext(ev_addr_ext), .bus_narrow(bus_narrow),
      .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .inj_mask_hi(inj_mask_hi), .inj_mask_lo(inj_mask_lo),
      .inj_mask_chk(inj_mask_chk), .irq(irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit run = 0;
   bit finished = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [1:0]  m_det, m_dis, m_ien;
   logic [7:0]  m_thr, m_cnt, m_aext;
   logic [31:0] m_chi, m_clo, m_alo, m_ihi, m_ilo;
   logic [15:0] m_cchk;
   logic [8:0]  m_ictl;
   logic        m_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_det = 0; m_dis = 0; m_ien = 0; m_thr = 8'd1; m_cnt = 0;
         m_chi = 0; m_clo = 0; m_alo = 0; m_aext = 0; m_cchk = 0;
         m_ihi = 0; m_ilo = 0; m_ictl = 0; m_irq = 0;
      end else begin
         logic [1:0] setv, clrv;
         int nxt;
         bit wr;
         wr = reg_en && reg_we;
         setv = 0;
         if (ev_sbe && !m_dis[0]) begin
            nxt = int'(m_cnt) + 1;
            if (m_thr != 0 && nxt >= int'(m_thr)) begin
               setv[0] = 1; m_cnt = 0;
            end else begin
               m_cnt = 8'(nxt % 256);
            end
         end
         if (ev_mbe && !m_dis[1]) setv[1] = 1;
         clrv = (wr && reg_addr == 4'd0) ? reg_wdata[1:0] : 2'b00;
         if (setv != 0 && m_det == 0) begin
            m_chi = ev_data_hi; m_clo = ev_data_lo; m_alo = ev_addr_lo;
            m_aext = ev_addr_ext;
            m_cchk = bus_narrow ? ev_chk : {8'h00, ev_chk[7:0]};
         end
         m_det = (m_det & ~clrv) | setv;
         if (wr) begin
            case (reg_addr)
               4'd1:  m_dis = reg_wdata[1:0];
               4'd2:  m_ien = reg_wdata[1:0];
               4'd3:  m_thr = reg_wdata[23:16];
               4'd9:  m_ihi = reg_wdata;
               4'd10: m_ilo = reg_wdata;
               4'd11: m_ictl = reg_wdata[8:0];
               default: ;
            endcase
         end
         m_irq = |(m_det & m_ien);
      end
   end

   function automatic logic [31:0] mread(int idx);
      case (idx)
         0: return {30'd0, m_det};
         1: return {30'd0, m_dis};
         2: return {30'd0, m_ien};
         3: return {8'd0, m_thr, 8'd0, m_cnt};
         4: return m_chi;
         5: return m_clo;
         6: return {16'd0, m_cchk};
         7: return m_alo;
         8: return {24'd0, m_aext};
         9: return m_ihi;
         10: return m_ilo;
         11: return {23'd0, m_ictl};
         default: return 32'd0;
      endcase
   endfunction

   // every-clock comparison of the free-running outputs
   always @(negedge clk) begin
      if (run && rst_n) begin
         chk("R8 irq vs model", 32'(irq), 32'(m_irq));
         chk("R9 inj_mask_hi vs model", inj_mask_hi, m_ictl[8] ? m_ihi : 32'd0);
         chk("R9 inj_mask_lo vs model", inj_mask_lo, m_ictl[8] ? m_ilo : 32'd0);
         chk("R9 inj_mask_chk vs model", 32'(inj_mask_chk), m_ictl[8] ? 32'(m_ictl[7:0]) : 32'd0);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(logic sbe, logic mbe, logic we, logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      ev_sbe = sbe; ev_mbe = mbe; reg_en = we; reg_we = we; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      ev_sbe = 0; ev_mbe = 0; reg_en = 0; reg_we = 0;
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      cyc(0, 0, 1, a, d);
   endtask

   task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      reg_en = 1; reg_we = 0; reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
      chk({tag, " (model)"}, reg_rdata, mread(int'(a)));
      reg_en = 0;
   endtask

   task automatic evdata(logic [31:0] hi, logic [31:0] lo, logic [15:0] c,
                         logic [31:0] al, logic [7:0] ae);
      ev_data_hi = hi; ev_data_lo = lo; ev_chk = c; ev_addr_lo = al; ev_addr_ext = ae;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      run = 1;

      // R1 reset state
      for (int i = 0; i < 12; i++) rd(4'(i), (i == 3) ? 32'h0001_0000 : 32'd0, "R1 reset value");
      chk("R1 irq low", 32'(irq), 0);

      // R2 / R6 / R7: first uncorrectable error captured, wide bus
      evdata(32'hDEAD_BEEF, 32'h0123_4567, 16'hA5C3, 32'h8000_1000, 8'h03);
      cyc(0, 1, 0, 0, 0);
      rd(RI_DETECT, 32'h2, "R2 mbe sets detect bit 1");
      rd(RI_CAP_HI, 32'hDEAD_BEEF, "R6 capture data hi");
      rd(RI_CAP_LO, 32'h0123_4567, "R6 capture data lo");
      rd(RI_CAP_CHK, 32'h0000_00C3, "R7 wide bus keeps 8 check bits");
      rd(RI_CAP_ALO, 32'h8000_1000, "R6 capture addr lo");
      rd(RI_CAP_AEXT, 32'h3, "R6 capture addr ext");

      // R6 frozen while pending
      evdata(32'h5555_AAAA, 32'h0, 16'hFFFF, 32'h0, 8'h7F);
      cyc(0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      rd(RI_DETECT, 32'h2, "R2 detect stays set");
      rd(RI_CAP_HI, 32'hDEAD_BEEF, "R6 capture frozen while pending");

      // R5 write-one-to-clear
      wr(RI_DETECT, 32'h1);
      rd(RI_DETECT, 32'h2, "R5 writing other bit leaves bit 1");
      wr(RI_DETECT, 32'h2);
      rd(RI_DETECT, 32'h0, "R5 clear bit 1");

      // R7 narrow bus keeps 16 check bits, capture reloads after clear (R6)
      bus_narrow = 1;
      evdata(32'h1111_2222, 32'h3333_4444, 16'hBEEF, 32'h0000_0040, 8'h01);
      cyc(0, 1, 0, 0, 0);
      rd(RI_CAP_CHK, 32'h0000_BEEF, "R7 narrow bus keeps 16 check bits");
      rd(RI_CAP_HI, 32'h1111_2222, "R6 reload after clear");
      wr(RI_DETECT, 32'hFFFF_FFFF);
      rd(RI_DETECT, 32'h0, "R5 all-ones clears everything");
      bus_narrow = 0;

      // R3 threshold 3
      wr(RI_SBEMGT, 32'h0003_0000);
      cyc(1, 0, 0, 0, 0);
      cyc(1, 0, 0, 0, 0);
      rd(RI_SBEMGT, 32'h0003_0002, "R3 count below threshold");
      rd(RI_DETECT, 32'h0, "R3 no report below threshold");
      evdata(32'h3333_4444, 32'h0, 16'h0012, 32'h0, 8'h0);
      cyc(1, 0, 0, 0, 0);
      rd(RI_DETECT, 32'h1, "R3 report at threshold");
      rd(RI_SBEMGT, 32'h0003_0000, "R3 count restarts");
      rd(RI_CAP_HI, 32'h3333_4444, "R6 capture on reported sbe");
      wr(RI_DETECT, 32'h1);

      // R3 threshold 0: count only
      wr(RI_SBEMGT, 32'h0);
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
      rd(RI_SBEMGT, 32'h0000_0003, "R3 threshold zero counts");
      rd(RI_DETECT, 32'h0, "R3 threshold zero never reports");

      // R4 masking
      wr(RI_DISABLE, 32'h3);
      cyc(1, 1, 0, 0, 0);
      rd(RI_DETECT, 32'h0, "R4 masked pulses ignored");
      rd(RI_SBEMGT, 32'h0000_0003, "R4 masked sbe not counted");
      wr(RI_DISABLE, 32'h1);
      cyc(0, 1, 0, 0, 0);
      rd(RI_DETECT, 32'h2, "R4 only sbe masked");
      wr(RI_DETECT, 32'h3);
      wr(RI_DISABLE, 32'h0);
      rd(RI_DISABLE, 32'h0, "R4 disable cleared");

      // R8 interrupt; threshold below current count (3) reports at once
      wr(RI_INTEN, 32'h3);
      wr(RI_SBEMGT, 32'h0001_0000);
      cyc(0, 1, 0, 0, 0);
      #1 chk("R8 irq with mbe enabled", 32'(irq), 32'd1);
      wr(RI_DETECT, 32'h2);
      #1 chk("R8 irq drops after clear", 32'(irq), 32'd0);
      wr(RI_INTEN, 32'h1);
      cyc(0, 1, 0, 0, 0);
      #1 chk("R8 mbe not enabled", 32'(irq), 32'd0);
      cyc(1, 0, 0, 0, 0);
      #1 chk("R8 sbe enabled raises irq", 32'(irq), 32'd1);
      rd(RI_SBEMGT, 32'h0001_0000, "R3 report when count passes lowered threshold");
      wr(RI_DETECT, 32'h3);

      // R5 set wins over simultaneous clear
      cyc(0, 1, 1, RI_DETECT, 32'h2);
      rd(RI_DETECT, 32'h2, "R5 set wins over clear");
      cyc(0, 1, 1, RI_DETECT, 32'h3);
      rd(RI_DETECT, 32'h2, "R5 set wins while pending");
      wr(RI_DETECT, 32'h3);

      // R9 injection
      wr(RI_INJ_HI, 32'hCAFE_F00D);
      wr(RI_INJ_LO, 32'h0BAD_C0DE);
      wr(RI_INJ_CTL, 32'h0000_005A);
      #1 chk("R9 disabled hi mask", inj_mask_hi, 32'd0);
      chk("R9 disabled chk mask", 32'(inj_mask_chk), 32'd0);
      wr(RI_INJ_CTL, 32'h0000_015A);
      #1 chk("R9 enabled hi mask", inj_mask_hi, 32'hCAFE_F00D);
      chk("R9 enabled lo mask", inj_mask_lo, 32'h0BAD_C0DE);
      chk("R9 enabled chk mask", 32'(inj_mask_chk), 32'h5A);
      wr(RI_INJ_CTL, 32'hFFFF_FFFF);
      rd(RI_INJ_CTL, 32'h0000_01FF, "R9 control reads bits 8:0");
      wr(RI_INJ_CTL, 32'h0);

      // R10 read-only capture, unmapped reads
      wr(RI_CAP_HI, 32'h0);
      wr(RI_CAP_CHK, 32'hFFFF);
      rd(RI_CAP_HI, 32'h3333_4444, "R10 capture hi not writable");
      rd(RI_CAP_CHK, 32'h0000_0012, "R10 capture chk not writable");
      wr(4'd13, 32'hFFFF_FFFF);
      rd(4'd13, 32'h0, "R10 unmapped index reads zero");
      rd(4'd15, 32'h0, "R10 unmapped index reads zero");

      repeat (2) @(posedge clk);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule